// File: doc/BRIEF.md
# LCD Interrupt Status Aggregator

This block gathers the interrupt events of a display controller's seven-channel frame DMA engine and of its controller-wide conditions into two status words, captures the frame ID of the event that first raised the interrupt, and drives a single level-sensitive interrupt line. Channel 0 reports into a primary status word that has one mask bit per source, each placed individually in control word 0. Channels 1 to 6 report into a secondary status word in four byte lanes, and their masks sit at the same bit positions in control word 5. Bus errors are recorded whatever the masks say, together with the number of the failing channel.

Software reaches the block through a single-cycle write port selected by a 3-bit code: 0 control word 0, 1 control word 3 (only its AC-bias count field, bits [19:16], is kept), 2 control word 5, 3 primary status, 4 secondary status. Status words are write-one-to-clear. A control word 0 write also acknowledges a quick disable and can flag the AC-bias condition. The interrupt line is produced by a two-state machine: IRQ_QUIET moves to IRQ_RAISED when any unmasked status bit is pending, and IRQ_RAISED moves back to IRQ_QUIET when none is.

Top module: `lcd_irq_agg`

## Requirements
- R1: After reset, both status words, both control words, the AC-bias count, the captured ID and the interrupt line are all zero.
- R2: Control word 0 keeps only bits [26:0] of a write, and control word 5 keeps only the bits set in 0x3f3f3f3f.
- R3: Channel 0 events set primary bits: start of frame bit 1 (only when that channel's start-of-frame enable is 1), end of frame bit 8 (only when its end-of-frame enable is 1), branch bit 9, underrun bit 4. An underrun on channel 1 sets primary bit 5.
- R4: For channel c from 1 to 6, a qualified start of frame sets secondary bit c-1, a qualified end of frame bit c+7, a branch bit c+15; an underrun on channels 2 to 6 sets secondary bit c+23.
- R5: A bus error on any channel sets primary bit 2 and writes the channel number into primary bits [30:28]; when several channels fail in one cycle the highest number is stored.
- R6: The controller-wide strobes set primary bits 0 (last frame done), 6 (output underrun), 11 (read status) and 12 (command).
- R7: The interrupt line goes high one clock after any primary bit is set whose mask is clear (bit 0 by control 0 bit 3, bit 1 by bit 4, bit 4 by bit 5, bit 5 by control 5 bit 24, bit 6 by control 0 bit 21, bit 7 by bit 11, bit 8 by bit 6, bit 9 by bit 20, bit 11 by bit 23, bit 12 by bit 24) or any secondary bit whose same-position bit in control word 5 is clear; bits 2, 3 and 10 never drive it. It falls one clock after no such bit remains.
- R8: Start-of-frame, end-of-frame and branch events count as unmasked when their mask is clear; bus errors always count. If the interrupt line is high when unmasked events arrive, summary bit 10 is set. If it is low, the frame ID of the lowest-numbered channel with an unmasked event is captured, and bit 10 is set when more than one unmasked event arrives in that cycle.
- R9: A primary status write clears each of bits [11:0] written as 1, and writing bit 2 as 1 also clears bits [30:28]; a secondary status write clears only bits set in both the data and 0x003e3f3f. An event in the same cycle wins over the clear.
- R10: A control word 0 write that takes bit 0 from 1 to 0 sets primary bit 7. A control word 0 write with bit 0 set and bit 22 clear, while the AC-bias count is nonzero, sets primary bit 3.
- R11: Writes with select codes 5, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_sof | input | NCH | Start-of-frame strobe per channel |
| ev_eof | input | NCH | End-of-frame strobe per channel |
| ev_branch | input | NCH | Branch-taken strobe per channel |
| ev_underrun | input | NCH | Input underrun strobe per channel |
| ev_buserr | input | NCH | Bus error strobe per channel |
| cmd_sof_ie | input | NCH | Start-of-frame interrupt enable from each channel's command word |
| cmd_eof_ie | input | NCH | End-of-frame interrupt enable from each channel's command word |
| frame_id | input | NCH*IDW | Current frame ID of each channel, channel 0 in the low slice |
| ev_last_done | input | 1 | Last frame done strobe |
| ev_out_underrun | input | 1 | Output underrun strobe |
| ev_read_status | input | 1 | Panel read status strobe |
| ev_command | input | 1 | Command complete strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code |
| wr_data | input | 32 | Write data |
| ctrl0_o | output | 32 | Control word 0 |
| ctrl5_o | output | 32 | Control word 5 |
| stat0_o | output | 32 | Primary status word |
| stat1_o | output | 32 | Secondary status word |
| irq_id_o | output | IDW | Captured frame ID |
| irq_o | output | 1 | Interrupt line |

## Verification
Status words, control words and the captured ID change at the same rising edge that samples an event strobe or a write, while the interrupt line changes one edge later because it is registered from the stored state. The bench drives inputs on the falling edge, samples 1 ns after the rising edge, and keeps a cycle-accurate model that follows exactly this one-edge and two-edge timing. Directed sequences check the line staying low just after an event and rising on the next cycle, and the summary rule for events arriving while the line is already high.

// File: rtl/lcd_irq_pkg.sv
package lcd_irq_pkg;

    localparam int REG_W = 32;
    localparam int PRI_W = 13;

    // primary status bit positions
    localparam int P_LDD  = 0;
    localparam int P_SOF0 = 1;
    localparam int P_BER  = 2;
    localparam int P_ABC  = 3;
    localparam int P_IU0  = 4;
    localparam int P_IU1  = 5;
    localparam int P_OU   = 6;
    localparam int P_QD   = 7;
    localparam int P_EOF0 = 8;
    localparam int P_BS0  = 9;
    localparam int P_SINT = 10;
    localparam int P_RDST = 11;
    localparam int P_CMD  = 12;
    localparam int BERCH_LSB = 28;
    localparam int BERCH_W   = 3;

    // control word 0 fields
    localparam int C0_ENB    = 0;
    localparam int C0_M_LDD  = 3;
    localparam int C0_M_SOF  = 4;
    localparam int C0_M_IU   = 5;
    localparam int C0_M_EOF  = 6;
    localparam int C0_M_QD   = 11;
    localparam int C0_M_BS   = 20;
    localparam int C0_M_OU   = 21;
    localparam int C0_INTBUF = 22;
    localparam int C0_M_RDST = 23;
    localparam int C0_M_CMD  = 24;
    localparam int C5_M_IU1  = 24;
    localparam int BIAS_LSB  = 16;
    localparam int BIAS_W    = 4;

    // secondary lane offsets (position = channel - 1 + offset)
    localparam int L_SOF = 0;
    localparam int L_EOF = 8;
    localparam int L_BS  = 16;
    localparam int L_IU  = 24;

    localparam logic [REG_W-1:0] CTRL0_KEEP = 32'h07ff_ffff;
    localparam logic [REG_W-1:0] CTRL5_KEEP = 32'h3f3f_3f3f;
    localparam logic [REG_W-1:0] STAT0_CLR  = 32'h0000_0fff;
    localparam logic [REG_W-1:0] STAT1_CLR  = 32'h003e_3f3f;

    typedef enum logic [2:0] {
        SEL_CTRL0 = 3'd0,
        SEL_CTRL3 = 3'd1,
        SEL_CTRL5 = 3'd2,
        SEL_STAT0 = 3'd3,
        SEL_STAT1 = 3'd4
    } wsel_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/lcd_irq_ctrl.sv
module lcd_irq_ctrl
    import lcd_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] ctrl0_q,
    output logic [REG_W-1:0] ctrl5_q,
    output logic             qd_set,
    output logic             abc_set
);

    logic [BIAS_W-1:0] bias_q;
    logic              wr_c0, wr_c3, wr_c5;

    assign wr_c0 = wr_en && (wr_sel == SEL_CTRL0);
    assign wr_c3 = wr_en && (wr_sel == SEL_CTRL3);
    assign wr_c5 = wr_en && (wr_sel == SEL_CTRL5);

    // status side effects of a control word 0 write
    assign qd_set  = wr_c0 && ctrl0_q[C0_ENB] && !wr_data[C0_ENB];
    assign abc_set = wr_c0 && (bias_q != '0) && wr_data[C0_ENB] && !wr_data[C0_INTBUF];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl0_q <= '0;
            ctrl5_q <= '0;
            bias_q  <= '0;
        end else begin
            if (wr_c0) ctrl0_q <= wr_data & CTRL0_KEEP;
            if (wr_c5) ctrl5_q <= wr_data & CTRL5_KEEP;
            if (wr_c3) bias_q  <= wr_data[BIAS_LSB +: BIAS_W];
        end
    end

    p_ctrl5_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_c5 |=> $stable(ctrl5_q));

endmodule

// File: rtl/lcd_irq_events.sv
module lcd_irq_events
    import lcd_irq_pkg::*;
#(
    parameter int NCH = 7,
    parameter int IDW = 32
) (
    input  logic [NCH-1:0]     sof_ev,
    input  logic [NCH-1:0]     eof_ev,
    input  logic [NCH-1:0]     bra_ev,
    input  logic [NCH-1:0]     und_ev,
    input  logic [NCH-1:0]     ber_ev,
    input  logic [NCH-1:0]     sof_ie,
    input  logic [NCH-1:0]     eof_ie,
    input  logic [NCH*IDW-1:0] ids,
    input  logic [REG_W-1:0]   ctrl0,
    input  logic [REG_W-1:0]   ctrl5,
    input  logic               irq_now,
    output logic [PRI_W-1:0]   p_set,
    output logic [REG_W-1:0]   s_set,
    output logic               ber_any,
    output logic [BERCH_W-1:0] ber_ch,
    output logic               sint_set,
    output logic               id_load,
    output logic [IDW-1:0]     id_val
);

    localparam int NKIND = 4;

    logic [NCH-1:0]   sof_q, eof_q, um_sof, um_eof, um_bra;
    logic [NKIND-1:0] hits [NCH];
    logic             unused_ctrl;

    assign sof_q       = sof_ev & sof_ie;
    assign eof_q       = eof_ev & eof_ie;
    assign ber_any     = |ber_ev;
    assign unused_ctrl = ^{ctrl0, ctrl5};

    // mask selection: channel 0 uses scattered bits, others the packed lanes
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        if (c == 0) begin : g_prim
            assign um_sof[c] = sof_q[c]  && !ctrl0[C0_M_SOF];
            assign um_eof[c] = eof_q[c]  && !ctrl0[C0_M_EOF];
            assign um_bra[c] = bra_ev[c] && !ctrl0[C0_M_BS];
        end else begin : g_sec
            assign um_sof[c] = sof_q[c]  && !ctrl5[c - 1 + L_SOF];
            assign um_eof[c] = eof_q[c]  && !ctrl5[c - 1 + L_EOF];
            assign um_bra[c] = bra_ev[c] && !ctrl5[c - 1 + L_BS];
        end
        assign hits[c] = {ber_ev[c], um_eof[c], um_sof[c], um_bra[c]};
    end

    always_comb begin : route
        p_set = '0;
        s_set = '0;
        p_set[P_SOF0] = sof_q[0];
        p_set[P_EOF0] = eof_q[0];
        p_set[P_BS0]  = bra_ev[0];
        p_set[P_IU0]  = und_ev[0];
        p_set[P_BER]  = ber_any;
        for (int c = 1; c < NCH; c++) begin
            s_set[c - 1 + L_SOF] = sof_q[c];
            s_set[c - 1 + L_EOF] = eof_q[c];
            s_set[c - 1 + L_BS]  = bra_ev[c];
            if (c == 1) p_set[P_IU1] = und_ev[c];
            else        s_set[c - 1 + L_IU] = und_ev[c];
        end
    end

    // walk channels upward: first unmasked event captures the ID when the
    // line is quiet, every further one flags the summary bit
    always_comb begin : summarize
        logic busy;
        busy     = irq_now;
        sint_set = 1'b0;
        id_load  = 1'b0;
        id_val   = '0;
        ber_ch   = '0;
        for (int c = 0; c < NCH; c++) begin
            if (ber_ev[c]) ber_ch = BERCH_W'(c);
            for (int k = 0; k < NKIND; k++) begin
                if (hits[c][k]) begin
                    if (busy) begin
                        sint_set = 1'b1;
                    end else begin
                        id_load = 1'b1;
                        id_val  = ids[c*IDW +: IDW];
                        busy    = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/lcd_irq_status.sv
module lcd_irq_status
    import lcd_irq_pkg::*;
#(
    parameter int IDW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr0,
    input  logic               clr1,
    input  logic [REG_W-1:0]   wdata,
    input  logic [PRI_W-1:0]   p_set,
    input  logic [REG_W-1:0]   s_set,
    input  logic               ber_any,
    input  logic [BERCH_W-1:0] ber_ch,
    input  logic               sint_set,
    input  logic               id_load,
    input  logic [IDW-1:0]     id_val,
    input  logic               qd_set,
    input  logic               abc_set,
    input  logic               g_ldd,
    input  logic               g_ou,
    input  logic               g_rdst,
    input  logic               g_cmd,
    output logic [REG_W-1:0]   stat0_q,
    output logic [REG_W-1:0]   stat1_q,
    output logic [IDW-1:0]     id_q
);

    logic [REG_W-1:0] s0_nxt, s1_nxt;

    always_comb begin : next_primary
        s0_nxt = stat0_q;
        if (clr0) begin
            s0_nxt = s0_nxt & ~(wdata & STAT0_CLR);
            if (wdata[P_BER]) s0_nxt[BERCH_LSB +: BERCH_W] = '0;
        end
        s0_nxt[PRI_W-1:0] = s0_nxt[PRI_W-1:0] | p_set;
        if (g_ldd)    s0_nxt[P_LDD]  = 1'b1;
        if (g_ou)     s0_nxt[P_OU]   = 1'b1;
        if (g_rdst)   s0_nxt[P_RDST] = 1'b1;
        if (g_cmd)    s0_nxt[P_CMD]  = 1'b1;
        if (qd_set)   s0_nxt[P_QD]   = 1'b1;
        if (abc_set)  s0_nxt[P_ABC]  = 1'b1;
        if (sint_set) s0_nxt[P_SINT] = 1'b1;
        if (ber_any)  s0_nxt[BERCH_LSB +: BERCH_W] = ber_ch;
    end

    always_comb begin : next_secondary
        s1_nxt = stat1_q;
        if (clr1) s1_nxt = s1_nxt & ~(wdata & STAT1_CLR);
        s1_nxt = s1_nxt | s_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat0_q <= '0;
            stat1_q <= '0;
            id_q    <= '0;
        end else begin
            stat0_q <= s0_nxt;
            stat1_q <= s1_nxt;
            if (id_load) id_q <= id_val;
        end
    end

    p_w1c_ldd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr0 && wdata[P_LDD] && !g_ldd) |=> !stat0_q[P_LDD]);

    p_id_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !id_load |=> $stable(id_q));

endmodule

// File: rtl/lcd_irq_line.sv
module lcd_irq_line
    import lcd_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] stat0,
    input  logic [REG_W-1:0] stat1,
    input  logic [REG_W-1:0] ctrl0,
    input  logic [REG_W-1:0] ctrl5,
    output logic             irq
);

    irq_state_e       state_q, state_nxt;
    logic [PRI_W-1:0] pri_en;
    logic             level;
    logic             unused_bits;

    assign unused_bits = ^{stat0[REG_W-1:PRI_W], ctrl0};

    always_comb begin : enables
        pri_en         = '0;
        pri_en[P_LDD]  = !ctrl0[C0_M_LDD];
        pri_en[P_SOF0] = !ctrl0[C0_M_SOF];
        pri_en[P_IU0]  = !ctrl0[C0_M_IU];
        pri_en[P_IU1]  = !ctrl5[C5_M_IU1];
        pri_en[P_OU]   = !ctrl0[C0_M_OU];
        pri_en[P_QD]   = !ctrl0[C0_M_QD];
        pri_en[P_EOF0] = !ctrl0[C0_M_EOF];
        pri_en[P_BS0]  = !ctrl0[C0_M_BS];
        pri_en[P_RDST] = !ctrl0[C0_M_RDST];
        pri_en[P_CMD]  = !ctrl0[C0_M_CMD];
        level = (|(stat0[PRI_W-1:0] & pri_en)) || (|(stat1 & ~ctrl5));
    end

    always_comb begin : transitions
        state_nxt = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (level)  state_nxt = IRQ_RAISED;
            IRQ_RAISED: if (!level) state_nxt = IRQ_QUIET;
            default:    state_nxt = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_nxt;
    end

    always_comb begin : outputs
        irq = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/lcd_irq_agg.sv
module lcd_irq_agg
    import lcd_irq_pkg::*;
#(
    parameter int NCH = 7,
    parameter int IDW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCH-1:0]     ev_sof,
    input  logic [NCH-1:0]     ev_eof,
    input  logic [NCH-1:0]     ev_branch,
    input  logic [NCH-1:0]     ev_underrun,
    input  logic [NCH-1:0]     ev_buserr,
    input  logic [NCH-1:0]     cmd_sof_ie,
    input  logic [NCH-1:0]     cmd_eof_ie,
    input  logic [NCH*IDW-1:0] frame_id,
    input  logic               ev_last_done,
    input  logic               ev_out_underrun,
    input  logic               ev_read_status,
    input  logic               ev_command,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   ctrl0_o,
    output logic [REG_W-1:0]   ctrl5_o,
    output logic [REG_W-1:0]   stat0_o,
    output logic [REG_W-1:0]   stat1_o,
    output logic [IDW-1:0]     irq_id_o,
    output logic               irq_o
);

    logic               qd_set, abc_set, clr0, clr1;
    logic [PRI_W-1:0]   p_set;
    logic [REG_W-1:0]   s_set;
    logic               ber_any, sint_set, id_load;
    logic [BERCH_W-1:0] ber_ch;
    logic [IDW-1:0]     id_val;

    assign clr0 = wr_en && (wr_sel == SEL_STAT0);
    assign clr1 = wr_en && (wr_sel == SEL_STAT1);

    lcd_irq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ctrl0_q (ctrl0_o),
        .ctrl5_q (ctrl5_o),
        .qd_set  (qd_set),
        .abc_set (abc_set)
    );

    lcd_irq_events #(.NCH(NCH), .IDW(IDW)) u_events (
        .sof_ev   (ev_sof),
        .eof_ev   (ev_eof),
        .bra_ev   (ev_branch),
        .und_ev   (ev_underrun),
        .ber_ev   (ev_buserr),
        .sof_ie   (cmd_sof_ie),
        .eof_ie   (cmd_eof_ie),
        .ids      (frame_id),
        .ctrl0    (ctrl0_o),
        .ctrl5    (ctrl5_o),
        .irq_now  (irq_o),
        .p_set    (p_set),
        .s_set    (s_set),
        .ber_any  (ber_any),
        .ber_ch   (ber_ch),
        .sint_set (sint_set),
        .id_load  (id_load),
        .id_val   (id_val)
    );

    lcd_irq_status #(.IDW(IDW)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr0     (clr0),
        .clr1     (clr1),
        .wdata    (wr_data),
        .p_set    (p_set),
        .s_set    (s_set),
        .ber_any  (ber_any),
        .ber_ch   (ber_ch),
        .sint_set (sint_set),
        .id_load  (id_load),
        .id_val   (id_val),
        .qd_set   (qd_set),
        .abc_set  (abc_set),
        .g_ldd    (ev_last_done),
        .g_ou     (ev_out_underrun),
        .g_rdst   (ev_read_status),
        .g_cmd    (ev_command),
        .stat0_q  (stat0_o),
        .stat1_q  (stat1_o),
        .id_q     (irq_id_o)
    );

    lcd_irq_line u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .stat0 (stat0_o),
        .stat1 (stat1_o),
        .ctrl0 (ctrl0_o),
        .ctrl5 (ctrl5_o),
        .irq   (irq_o)
    );

    p_qd_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CTRL0 && ctrl0_o[C0_ENB] && !wr_data[C0_ENB])
        |=> stat0_o[P_QD]);

    p_ber_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_buserr) |=> stat0_o[P_BER]);

    p_sint_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && (|ev_buserr)) |=> stat0_o[P_SINT]);

    p_sec_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat1_o & ~ctrl5_o)) |=> irq_o);

    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat0_o == '0 && stat1_o == '0) |=> !irq_o);

endmodule

// File: tb/lcd_irq_agg_test.sv
module lcd_irq_agg_test;

    localparam int NCH = 7;
    localparam int IDW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [NCH-1:0]     ev_sof, ev_eof, ev_branch, ev_underrun, ev_buserr;
    logic [NCH-1:0]     cmd_sof_ie, cmd_eof_ie;
    logic [NCH*IDW-1:0] frame_id;
    logic               ev_last_done, ev_out_underrun, ev_read_status, ev_command;
    logic               wr_en;
    logic [2:0]         wr_sel;
    logic [31:0]        wr_data;
    logic [31:0]        ctrl0_o, ctrl5_o, stat0_o, stat1_o;
    logic [IDW-1:0]     irq_id_o;
    logic               irq_o;

    lcd_irq_agg #(.NCH(NCH), .IDW(IDW)) uut (
        .clk(clk), .rst_n(rst_n),
        .ev_sof(ev_sof), .ev_eof(ev_eof), .ev_branch(ev_branch),
        .ev_underrun(ev_underrun), .ev_buserr(ev_buserr),
        .cmd_sof_ie(cmd_sof_ie), .cmd_eof_ie(cmd_eof_ie), .frame_id(frame_id),
        .ev_last_done(ev_last_done), .ev_out_underrun(ev_out_underrun),
        .ev_read_status(ev_read_status), .ev_command(ev_command),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ctrl0_o(ctrl0_o), .ctrl5_o(ctrl5_o), .stat0_o(stat0_o),
        .stat1_o(stat1_o), .irq_id_o(irq_id_o), .irq_o(irq_o)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [31:0] m_s0, m_s1, m_c0, m_c5, m_id;
    logic [3:0]  m_bias;
    logic        m_irq;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic lvl(input logic [31:0] s0, s1, c0, c5);
        logic [12:0] en;
        en = '0;
        en[0] = !c0[3];  en[1] = !c0[4];   en[4] = !c0[5];   en[5] = !c5[24];
        en[6] = !c0[21]; en[7] = !c0[11];  en[8] = !c0[6];   en[9] = !c0[20];
        en[11] = !c0[23]; en[12] = !c0[24];
        return (|(s0[12:0] & en)) || (|(s1 & ~c5));
    endfunction

    task automatic idle_inputs();
        ev_sof = '0; ev_eof = '0; ev_branch = '0; ev_underrun = '0; ev_buserr = '0;
        cmd_sof_ie = '0; cmd_eof_ie = '0; frame_id = '0;
        ev_last_done = 0; ev_out_underrun = 0; ev_read_status = 0; ev_command = 0;
        wr_en = 0; wr_sel = '0; wr_data = '0;
    endtask

    task automatic step();
        logic [31:0] n0, n1, nc0, nc5, nid;
        logic [3:0]  nb;
        logic        nirq;
        logic [NCH-1:0] sq, eq;
        int total, firstc;
        nirq = lvl(m_s0, m_s1, m_c0, m_c5);
        n0 = m_s0; n1 = m_s1; nc0 = m_c0; nc5 = m_c5; nb = m_bias; nid = m_id;
        if (wr_en) begin
            case (wr_sel)
                3'd0: begin
                    if (m_c0[0] && !wr_data[0]) n0[7] = 1'b1;
                    if (m_bias != 0 && wr_data[0] && !wr_data[22]) n0[3] = 1'b1;
                    nc0 = wr_data & 32'h07ff_ffff;
                end
                3'd1: nb = wr_data[19:16];
                3'd2: nc5 = wr_data & 32'h3f3f_3f3f;
                3'd3: begin
                    n0 = n0 & ~(wr_data & 32'h0000_0fff);
                    if (wr_data[2]) n0[30:28] = 3'd0;
                end
                3'd4: n1 = n1 & ~(wr_data & 32'h003e_3f3f);
                default: ;
            endcase
        end
        sq = ev_sof & cmd_sof_ie;
        eq = ev_eof & cmd_eof_ie;
        total = 0; firstc = -1;
        for (int c = 0; c < NCH; c++) begin
            int k;
            k = 0;
            if (c == 0) begin
                if (sq[0]) begin n0[1] = 1'b1; if (!m_c0[4]) k++; end
                if (eq[0]) begin n0[8] = 1'b1; if (!m_c0[6]) k++; end
                if (ev_branch[0]) begin n0[9] = 1'b1; if (!m_c0[20]) k++; end
                if (ev_underrun[0]) n0[4] = 1'b1;
            end else begin
                if (sq[c]) begin n1[c-1] = 1'b1; if (!m_c5[c-1]) k++; end
                if (eq[c]) begin n1[c+7] = 1'b1; if (!m_c5[c+7]) k++; end
                if (ev_branch[c]) begin n1[c+15] = 1'b1; if (!m_c5[c+15]) k++; end
                if (ev_underrun[c]) begin
                    if (c == 1) n0[5] = 1'b1;
                    else        n1[c+23] = 1'b1;
                end
            end
            if (ev_buserr[c]) begin n0[2] = 1'b1; n0[30:28] = 3'(c); k++; end
            if (k > 0 && firstc < 0) firstc = c;
            total += k;
        end
        if (total > 0) begin
            if (m_irq) n0[10] = 1'b1;
            else begin
                nid = frame_id[firstc*IDW +: IDW];
                if (total > 1) n0[10] = 1'b1;
            end
        end
        if (ev_last_done)    n0[0]  = 1'b1;
        if (ev_out_underrun) n0[6]  = 1'b1;
        if (ev_read_status)  n0[11] = 1'b1;
        if (ev_command)      n0[12] = 1'b1;
        @(posedge clk);
        #1;
        m_s0 = n0; m_s1 = n1; m_c0 = nc0; m_c5 = nc5; m_bias = nb; m_id = nid; m_irq = nirq;
        chk("R3 primary status", stat0_o, m_s0);
        chk("R4 secondary status", stat1_o, m_s1);
        chk("R2 control word 0", ctrl0_o, m_c0);
        chk("R2 control word 5", ctrl5_o, m_c5);
        chk("R8 captured id", irq_id_o, m_id);
        chk("R7 interrupt line", {31'd0, irq_o}, {31'd0, m_irq});
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        step();
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_s0 = '0; m_s1 = '0; m_c0 = '0; m_c5 = '0; m_id = '0; m_bias = '0; m_irq = 1'b0;
        chk("R1 reset primary", stat0_o, 32'd0);
        chk("R1 reset secondary", stat1_o, 32'd0);
        chk("R1 reset ctrl0", ctrl0_o, 32'd0);
        chk("R1 reset id", irq_id_o, 32'd0);
        chk("R1 reset line", {31'd0, irq_o}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        idle_inputs();
        do_reset();

        // R3: channel 0 start of frame gated by its enable, ID captured
        ev_sof[0] = 1'b1;
        step();
        chk("R3 sof ignored without enable", stat0_o, 32'h0);
        ev_sof[0] = 1'b1; cmd_sof_ie[0] = 1'b1; frame_id[0 +: IDW] = 32'hA0;
        step();
        chk("R3 sof ch0 bit1", stat0_o, 32'h2);
        chk("R8 id captured", irq_id_o, 32'hA0);
        chk("R7 line still low", {31'd0, irq_o}, 32'd0);
        step();
        chk("R7 line high one clock later", {31'd0, irq_o}, 32'd1);

        // R8: event while line high sets summary, ID kept
        ev_eof[3] = 1'b1; cmd_eof_ie[3] = 1'b1; frame_id[3*IDW +: IDW] = 32'hB3;
        step();
        chk("R8 summary set", stat0_o, 32'h402);
        chk("R4 eof ch3 bit10", stat1_o, 32'h400);
        chk("R8 id kept", irq_id_o, 32'hA0);

        // R9: clears
        wr(3'd3, 32'h0000_0fff);
        chk("R9 primary cleared", stat0_o, 32'h0);
        wr(3'd4, 32'hffff_ffff);
        chk("R9 secondary cleared", stat1_o, 32'h0);
        step();
        chk("R7 line falls", {31'd0, irq_o}, 32'd0);

        // R4: underrun routing and sticky lanes
        ev_underrun[6] = 1'b1; ev_underrun[1] = 1'b1;
        step();
        chk("R4 underrun ch6 bit29", stat1_o, 32'h2000_0000);
        chk("R3 underrun ch1 bit5", stat0_o, 32'h20);
        wr(3'd4, 32'hffff_ffff);
        chk("R9 underrun lane not clearable", stat1_o, 32'h2000_0000);

        // R5: simultaneous bus errors
        do_reset();
        ev_buserr[2] = 1'b1; ev_buserr[5] = 1'b1;
        frame_id[2*IDW +: IDW] = 32'h22; frame_id[5*IDW +: IDW] = 32'h55;
        step();
        chk("R5 bus error highest channel", stat0_o, 32'h5000_0404);
        chk("R8 lowest channel id", irq_id_o, 32'h22);
        wr(3'd3, 32'h0000_0004);
        chk("R9 bus error clears field", stat0_o, 32'h0000_0400);

        // R6: controller-wide strobes
        do_reset();
        ev_last_done = 1; ev_out_underrun = 1; ev_read_status = 1; ev_command = 1;
        step();
        chk("R6 global bits", stat0_o, 32'h0000_1841);
        wr(3'd3, 32'hffff_ffff);
        chk("R9 command bit not clearable", stat0_o, 32'h0000_1000);

        // R10: quick disable and AC-bias
        do_reset();
        wr(3'd0, 32'h1);
        chk("R10 no bias flag with zero count", stat0_o, 32'h0);
        wr(3'd0, 32'h0);
        chk("R10 quick disable", stat0_o, 32'h80);
        wr(3'd1, 32'h0005_0000);
        wr(3'd0, 32'h1);
        chk("R10 bias flag", stat0_o, 32'h88);
        wr(3'd3, 32'h8);
        wr(3'd0, 32'h0040_0001);
        chk("R10 internal buffer blocks bias flag", stat0_o, 32'h80);

        // R2: control word masks
        do_reset();
        wr(3'd0, 32'hffff_ffff);
        chk("R2 ctrl0 kept bits", ctrl0_o, 32'h07ff_ffff);
        wr(3'd2, 32'hffff_ffff);
        chk("R2 ctrl5 kept bits", ctrl5_o, 32'h3f3f_3f3f);

        // R7/R8: masked event does not raise line or capture ID
        do_reset();
        wr(3'd0, 32'h10);
        ev_sof[0] = 1'b1; cmd_sof_ie[0] = 1'b1; frame_id[0 +: IDW] = 32'h77;
        step();
        step();
        chk("R7 masked stays low", {31'd0, irq_o}, 32'd0);
        chk("R8 masked no capture", irq_id_o, 32'h0);

        // R11: unused selects
        do_reset();
        wr(3'd5, 32'hffff_ffff);
        wr(3'd6, 32'hffff_ffff);
        wr(3'd7, 32'hffff_ffff);
        chk("R11 ctrl0 untouched", ctrl0_o, 32'h0);
        chk("R11 status untouched", stat0_o, 32'h0);

        // random phase against the model
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            ev_sof      = NCH'($urandom & $urandom & $urandom);
            ev_eof      = NCH'($urandom & $urandom & $urandom);
            ev_branch   = NCH'($urandom & $urandom & $urandom);
            ev_underrun = NCH'($urandom & $urandom & $urandom & $urandom);
            ev_buserr   = NCH'($urandom & $urandom & $urandom & $urandom);
            cmd_sof_ie  = NCH'($urandom);
            cmd_eof_ie  = NCH'($urandom);
            for (int c = 0; c < NCH; c++) frame_id[c*IDW +: IDW] = $urandom;
            ev_last_done    = ($urandom % 8) == 0;
            ev_out_underrun = ($urandom % 8) == 0;
            ev_read_status  = ($urandom % 8) == 0;
            ev_command      = ($urandom % 16) == 0;
            wr_en   = ($urandom % 3) == 0;
            wr_sel  = 3'($urandom);
            wr_data = $urandom;
            step();
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule